// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, called A and B, through a pair of one-way paths. Each path owns a capture register, a capture clock, a source select and an output enable. A path either forwards the live value of the bus it listens to, or replays the value its register last captured, or leaves its destination bus undriven. A build-time option complements every driven word. Both registers capture on their own rising clock edges whatever the select and enable inputs say, so either bus can be sampled while data is being forwarded.

The bidirectional pins are modelled with separate external driver inputs per bus. An on-chip resolver combines each bus from its external driver, the transceiver's own port driver, or the value the bus held on the previous system clock. A per-bus flag reports an external driver and a port driver disagreeing on the same bus. If both paths forward live data and both external drivers let go, the pair forms a holding loop and each bus keeps its last value.

Top module: `regxcvr_top`

## Requirements
- R1: A rising edge of `cap_ab_clk` stores the current A bus value into the A-side register, for every setting of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R2: A rising edge of `cap_ba_clk` stores the current B bus value into the B-side register, for every setting of the selects and enables.
- R3: While `oe_ab` is 1 and no external driver is on B, the B bus carries the A bus value when `sel_ab` is 0 and the A-side register when `sel_ab` is 1 (each passed through the option of R10).
- R4: While `oe_ba_n` is 0 and no external driver is on A, the A bus carries the B bus value when `sel_ba` is 0 and the B-side register when `sel_ba` is 1 (each passed through the option of R10).
- R5: With `oe_ab` at 0 and `oe_ba_n` at 1 neither port drives: each bus shows its external value when enabled, and neither conflict flag is raised.
- R6: A bus with no active driver keeps the value it had on the previous `clk` edge; after reset both buses read 0.
- R7: With both ports enabled, both selects at 0 and both external drivers released, each bus keeps its last value for as long as that state lasts.
- R8: While the B port forwards live A data, clocking both capture clocks on the same edge loads the A-side register with the A value and the B-side register with the driven B value.
- R9: When the live and stored values of a path are equal, toggling that path's select leaves its driven output unchanged.
- R10: With `INVERT` = 1 every driven word is the bitwise complement of its source; captured words are the bus values as they appear, not complemented again.
- R11: When an external driver and the port driver are both active on one bus with differing words, that bus's conflict flag is 1 and the bus shows the external word; with equal words the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bus-hold registers |
| rst_n | input | 1 | Active-low reset of the bus-hold registers |
| cap_ab_clk | input | 1 | Capture clock of the A-side register |
| cap_ba_clk | input | 1 | Capture clock of the B-side register |
| sel_ab | input | 1 | B port source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A port source: 0 live B, 1 stored B |
| oe_ab | input | 1 | Active-high enable of the B port driver |
| oe_ba_n | input | 1 | Active-low enable of the A port driver |
| ext_a | input | WIDTH | External word offered on bus A |
| ext_a_en | input | 1 | External driver of bus A active |
| ext_b | input | WIDTH | External word offered on bus B |
| ext_b_en | input | 1 | External driver of bus B active |
| a_bus | output | WIDTH | Resolved value of bus A |
| b_bus | output | WIDTH | Resolved value of bus B |
| a_conflict | output | 1 | External and port drivers disagree on A |
| b_conflict | output | 1 | External and port drivers disagree on B |

## Verification
The hardest state to reach is the holding loop, where each bus is driven only by the other through live paths: it needs both buses to carry consistent values before the external drivers let go, otherwise the held words mean nothing. The stimulus first drives A externally with both live paths on, lets a system clock edge record the settled pair, then releases A and watches both buses over several clocks, on a plain and on a complementing instance. The registers have no reset, so every stored-path check is preceded by a capture of a known bus word.

// File: rtl/regxcvr_pkg.sv
package regxcvr_pkg;
   localparam int unsigned DEF_WIDTH = 8;

   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;
endpackage

// File: rtl/regxcvr_capture.sv
module regxcvr_capture #(
   parameter int unsigned WIDTH = regxcvr_pkg::DEF_WIDTH
) (
   input  logic             cap_clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   // Capture register without reset; loads on every rising edge.
   always_ff @(posedge cap_clk) begin
      q <= d;
   end
endmodule

// File: rtl/regxcvr_path.sv
module regxcvr_path #(
   parameter int unsigned WIDTH  = regxcvr_pkg::DEF_WIDTH,
   parameter bit          INVERT = 1'b0
) (
   input  regxcvr_pkg::src_sel_e sel,
   input  logic [WIDTH-1:0]      live,
   input  logic [WIDTH-1:0]      stored,
   output logic [WIDTH-1:0]      drv
);
   logic [WIDTH-1:0] pick_stored;
   logic [WIDTH-1:0] merged;

   assign pick_stored = {WIDTH{sel == regxcvr_pkg::SRC_STORED}};

   // Consensus term keeps the output steady when both sources agree.
   assign merged = (live & ~pick_stored) | (stored & pick_stored) | (live & stored);

   generate
      if (INVERT) begin : g_inv
         assign drv = ~merged;
      end else begin : g_buf
         assign drv = merged;
      end
   endgenerate
endmodule

// File: rtl/regxcvr_core.sv
module regxcvr_core #(
   parameter int unsigned WIDTH  = regxcvr_pkg::DEF_WIDTH,
   parameter bit          INVERT = 1'b0
) (
   input  logic             cap_ab_clk,
   input  logic             cap_ba_clk,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic             oe_ab,
   input  logic             oe_ba_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe,
   output logic [WIDTH-1:0] reg_a_q,
   output logic [WIDTH-1:0] reg_b_q
);
   import regxcvr_pkg::*;

   regxcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
      .cap_clk (cap_ab_clk),
      .d       (a_in),
      .q       (reg_a_q)
   );

   regxcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
      .cap_clk (cap_ba_clk),
      .d       (b_in),
      .q       (reg_b_q)
   );

   regxcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ab (
      .sel    (src_sel_e'(sel_ab)),
      .live   (a_in),
      .stored (reg_a_q),
      .drv    (b_out)
   );

   regxcvr_path #(.WIDTH(WIDTH), .INVERT(INVERT)) u_path_ba (
      .sel    (src_sel_e'(sel_ba)),
      .live   (b_in),
      .stored (reg_b_q),
      .drv    (a_out)
   );

   // Opposite enable polarities: B port high-true, A port low-true.
   assign b_oe = oe_ab;
   assign a_oe = ~oe_ba_n;
endmodule

// File: rtl/regxcvr_resolve.sv
module regxcvr_resolve #(
   parameter int unsigned WIDTH  = regxcvr_pkg::DEF_WIDTH,
   parameter bit          INVERT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] ext_a,
   input  logic             ext_a_en,
   input  logic [WIDTH-1:0] ext_b,
   input  logic             ext_b_en,
   input  logic             a_oe,
   input  logic             b_oe,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] reg_a_q,
   input  logic [WIDTH-1:0] reg_b_q,
   input  logic [WIDTH-1:0] a_drv,
   input  logic [WIDTH-1:0] b_drv,
   output logic [WIDTH-1:0] a_bus,
   output logic [WIDTH-1:0] b_bus,
   output logic             a_conflict,
   output logic             b_conflict
);
   logic [WIDTH-1:0] a_hold, b_hold;
   logic [WIDTH-1:0] a_fixed, b_fixed;
   logic [WIDTH-1:0] a_from_b, b_from_a;
   logic [WIDTH-1:0] a_stored_word, b_stored_word;
   logic             a_follows_b, b_follows_a;
   logic             past_ok;

   // Same data-path polarity as the port drivers.
   generate
      if (INVERT) begin : g_inv
         assign a_stored_word = ~reg_b_q;
         assign b_stored_word = ~reg_a_q;
         assign a_from_b      = ~b_fixed;
         assign b_from_a      = ~a_fixed;
      end else begin : g_buf
         assign a_stored_word = reg_b_q;
         assign b_stored_word = reg_a_q;
         assign a_from_b      = b_fixed;
         assign b_from_a      = a_fixed;
      end
   endgenerate

   // A bus value that depends on the other bus only through a live path.
   assign a_follows_b = ~ext_a_en & a_oe & ~sel_ba;
   assign b_follows_a = ~ext_b_en & b_oe & ~sel_ab;

   // Value of each bus when it does not follow the other one.
   assign a_fixed = ext_a_en ? ext_a : (a_oe ? a_stored_word : a_hold);
   assign b_fixed = ext_b_en ? ext_b : (b_oe ? b_stored_word : b_hold);

   always_comb begin
      if (a_follows_b && b_follows_a) begin
         a_bus = a_hold;
         b_bus = b_hold;
      end else begin
         a_bus = a_follows_b ? a_from_b : a_fixed;
         b_bus = b_follows_a ? b_from_a : b_fixed;
      end
   end

   assign a_conflict = ext_a_en & a_oe & (ext_a != a_drv);
   assign b_conflict = ext_b_en & b_oe & (ext_b != b_drv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_hold  <= '0;
         b_hold  <= '0;
         past_ok <= 1'b0;
      end else begin
         a_hold  <= a_bus;
         b_hold  <= b_bus;
         past_ok <= 1'b1;
      end
   end

   assert_hold_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !ext_a_en && !a_oe) |-> (a_bus == $past(a_bus)));
   assert_hold_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !ext_b_en && !b_oe) |-> (b_bus == $past(b_bus)));
   assert_loop_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && a_follows_b && b_follows_a) |->
      (a_bus == $past(a_bus) && b_bus == $past(b_bus)));
   assert_ext_wins_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
      a_conflict |-> (a_bus == ext_a));
   assert_ext_wins_b_R11: assert property (@(posedge clk) disable iff (!rst_n)
      b_conflict |-> (b_bus == ext_b));
endmodule

// File: rtl/regxcvr_top.sv
module regxcvr_top #(
   parameter int unsigned WIDTH  = regxcvr_pkg::DEF_WIDTH,
   parameter bit          INVERT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_ab_clk,
   input  logic             cap_ba_clk,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic             oe_ab,
   input  logic             oe_ba_n,
   input  logic [WIDTH-1:0] ext_a,
   input  logic             ext_a_en,
   input  logic [WIDTH-1:0] ext_b,
   input  logic             ext_b_en,
   output logic [WIDTH-1:0] a_bus,
   output logic [WIDTH-1:0] b_bus,
   output logic             a_conflict,
   output logic             b_conflict
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("regxcvr_top: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] a_drv, b_drv, reg_a_q, reg_b_q;
   logic             a_oe, b_oe;
   logic             live_loop;

   regxcvr_core #(.WIDTH(WIDTH), .INVERT(INVERT)) u_core (
      .cap_ab_clk (cap_ab_clk),
      .cap_ba_clk (cap_ba_clk),
      .sel_ab     (sel_ab),
      .sel_ba     (sel_ba),
      .oe_ab      (oe_ab),
      .oe_ba_n    (oe_ba_n),
      .a_in       (a_bus),
      .b_in       (b_bus),
      .a_out      (a_drv),
      .a_oe       (a_oe),
      .b_out      (b_drv),
      .b_oe       (b_oe),
      .reg_a_q    (reg_a_q),
      .reg_b_q    (reg_b_q)
   );

   regxcvr_resolve #(.WIDTH(WIDTH), .INVERT(INVERT)) u_resolve (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_a      (ext_a),
      .ext_a_en   (ext_a_en),
      .ext_b      (ext_b),
      .ext_b_en   (ext_b_en),
      .a_oe       (a_oe),
      .b_oe       (b_oe),
      .sel_ab     (sel_ab),
      .sel_ba     (sel_ba),
      .reg_a_q    (reg_a_q),
      .reg_b_q    (reg_b_q),
      .a_drv      (a_drv),
      .b_drv      (b_drv),
      .a_bus      (a_bus),
      .b_bus      (b_bus),
      .a_conflict (a_conflict),
      .b_conflict (b_conflict)
   );

   assign live_loop = oe_ab & ~oe_ba_n & ~sel_ab & ~sel_ba & ~ext_a_en & ~ext_b_en;

   // Resolver output must match the core's driver whenever a port owns its bus.
   assert_bport_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_ab && !ext_b_en && !live_loop) |-> (b_bus == b_drv));
   assert_aport_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_ba_n && !ext_a_en && !live_loop) |-> (a_bus == a_drv));
   assert_isolation_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_ab && oe_ba_n) |-> (!a_conflict && !b_conflict));
endmodule

// File: tb/tb_regxcvr_top.sv
module tb_regxcvr_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cap_ab_clk = 1'b0, cap_ba_clk = 1'b0;
   logic         sel_ab = 1'b0, sel_ba = 1'b0, oe_ab = 1'b0, oe_ba_n = 1'b1;
   logic [W-1:0] ext_a = '0, ext_b = '0;
   logic         ext_a_en = 1'b0, ext_b_en = 1'b0;
   logic [W-1:0] a_bus, b_bus, a_bus_i, b_bus_i;
   logic         a_cf, b_cf, a_cf_i, b_cf_i;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   regxcvr_top #(.WIDTH(W), .INVERT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
      .ext_a(ext_a), .ext_a_en(ext_a_en), .ext_b(ext_b), .ext_b_en(ext_b_en),
      .a_bus(a_bus), .b_bus(b_bus), .a_conflict(a_cf), .b_conflict(b_cf));

   regxcvr_top #(.WIDTH(W), .INVERT(1'b1)) dut_inv (
      .clk(clk), .rst_n(rst_n), .cap_ab_clk(cap_ab_clk), .cap_ba_clk(cap_ba_clk),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
      .ext_a(ext_a), .ext_a_en(ext_a_en), .ext_b(ext_b), .ext_b_en(ext_b_en),
      .a_bus(a_bus_i), .b_bus(b_bus_i), .a_conflict(a_cf_i), .b_conflict(b_cf_i));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic neg();
      @(negedge clk);
   endtask

   task automatic pulse(input bit ab, input bit ba);
      #1;
      if (ab) cap_ab_clk = 1'b1;
      if (ba) cap_ba_clk = 1'b1;
      #1;
      cap_ab_clk = 1'b0;
      cap_ba_clk = 1'b0;
      #1;
   endtask

   task automatic quiet();
      oe_ab = 1'b0; oe_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
      ext_a_en = 1'b0; ext_b_en = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [W-1:0] v;
      repeat (3) @(posedge clk);
      neg();
      rst_n = 1'b1;
      #1;
      // R6: buses read 0 after reset with nothing driving
      chk("R6 reset a", a_bus, 8'h00);
      chk("R6 reset b", b_bus, 8'h00);
      chk("R5 reset conflicts", {6'd0, a_cf, b_cf}, 8'h00);

      // R3 live A->B sweep, R10 complement on inverting instance
      neg();
      oe_ab = 1'b1; sel_ab = 1'b0; ext_a_en = 1'b1;
      for (int i = 0; i < 256; i++) begin
         ext_a = W'(i);
         #1;
         chk("R3 live b", b_bus, W'(i));
         chk("R10 live b inv", b_bus_i, ~W'(i));
      end

      // R4 live B->A sweep
      neg(); quiet();
      oe_ba_n = 1'b0; sel_ba = 1'b0; ext_b_en = 1'b1;
      for (int i = 0; i < 256; i++) begin
         ext_b = W'(255 - i);
         #1;
         chk("R4 live a", a_bus, W'(255 - i));
         chk("R10 live a inv", a_bus_i, ~W'(255 - i));
      end

      // R1: capture A under every select/enable setting, replay through stored path
      for (int k = 0; k < 8; k++) begin
         neg(); quiet();
         v = W'(8'h1D * (k + 1));
         ext_a = v; ext_a_en = 1'b1;
         sel_ab = k[0]; oe_ab = k[1]; sel_ba = k[2];
         pulse(1'b1, 1'b0);
         ext_a = 8'h00; oe_ab = 1'b1; sel_ab = 1'b1; sel_ba = 1'b0;
         #1;
         chk("R1 stored a->b", b_bus, v);
         chk("R10 stored a->b inv", b_bus_i, ~v);
      end

      // R2: capture B under every select/enable setting
      for (int k = 0; k < 8; k++) begin
         neg(); quiet();
         v = W'(8'h2B * (k + 3));
         ext_b = v; ext_b_en = 1'b1;
         sel_ba = k[0]; oe_ab = k[1]; sel_ab = k[2];
         pulse(1'b0, 1'b1);
         ext_b_en = 1'b0; oe_ab = 1'b0; sel_ab = 1'b0;
         oe_ba_n = 1'b0; sel_ba = 1'b1;
         #1;
         chk("R2 stored b->a", a_bus, v);
         chk("R10 stored b->a inv", a_bus_i, ~v);
      end

      // R5 isolation, R6 hold after release
      neg(); quiet();
      ext_a = 8'h77; ext_a_en = 1'b1; ext_b = 8'h88; ext_b_en = 1'b1;
      #1;
      chk("R5 iso a", a_bus, 8'h77);
      chk("R5 iso b", b_bus, 8'h88);
      chk("R5 iso flags", {6'd0, a_cf, b_cf}, 8'h00);
      neg();
      ext_a_en = 1'b0; ext_b_en = 1'b0;
      repeat (3) neg();
      chk("R6 hold a", a_bus, 8'h77);
      chk("R6 hold b", b_bus, 8'h88);
      chk("R6 hold b inv", b_bus_i, 8'h88);

      // R7 holding loop
      neg(); quiet();
      ext_a = 8'h5A; ext_a_en = 1'b1;
      oe_ab = 1'b1; oe_ba_n = 1'b0;
      #1;
      chk("R7 setup b", b_bus, 8'h5A);
      chk("R7 setup b inv", b_bus_i, 8'hA5);
      chk("R11 agree no flag", {6'd0, a_cf, a_cf_i}, 8'h00);
      neg();
      ext_a_en = 1'b0;
      #1;
      chk("R7 loop a", a_bus, 8'h5A);
      chk("R7 loop b inv", b_bus_i, 8'hA5);
      repeat (4) neg();
      chk("R7 loop a later", a_bus, 8'h5A);
      chk("R7 loop b later", b_bus, 8'h5A);
      chk("R7 loop a inv later", a_bus_i, 8'h5A);
      chk("R7 loop b inv later", b_bus_i, 8'hA5);

      // R8 both registers loaded on one shared edge
      neg(); quiet();
      ext_a = 8'hC3; ext_a_en = 1'b1; oe_ab = 1'b1; sel_ab = 1'b0;
      pulse(1'b1, 1'b1);
      ext_a = 8'h00; sel_ab = 1'b1; ext_a_en = 1'b0;
      #1;
      chk("R8 reg a", b_bus, 8'hC3);
      chk("R8 reg a inv", b_bus_i, 8'h3C);
      oe_ab = 1'b0; oe_ba_n = 1'b0; sel_ba = 1'b1;
      #1;
      chk("R8 reg b", a_bus, 8'hC3);
      chk("R8 reg b inv", a_bus_i, 8'hC3);

      // R9 select toggling with equal and unequal sources
      neg(); quiet();
      ext_a = 8'h69; ext_a_en = 1'b1;
      pulse(1'b1, 1'b0);
      oe_ab = 1'b1;
      for (int t = 0; t < 6; t++) begin
         sel_ab = t[0];
         #1;
         chk("R9 steady b", b_bus, 8'h69);
         chk("R9 steady b inv", b_bus_i, 8'h96);
      end
      ext_a = 8'h00;
      sel_ab = 1'b0; #1;
      chk("R9 live pick", b_bus, 8'h00);
      sel_ab = 1'b1; #1;
      chk("R9 stored pick", b_bus, 8'h69);

      // R11 conflict on bus B
      neg(); quiet();
      ext_a = 8'hF0; ext_a_en = 1'b1; oe_ab = 1'b1;
      ext_b = 8'h0F; ext_b_en = 1'b1;
      #1;
      chk("R11 flag set", {7'd0, b_cf}, 8'h01);
      chk("R11 ext wins", b_bus, 8'h0F);
      ext_b = 8'hF0;
      #1;
      chk("R11 equal no flag", {7'd0, b_cf}, 8'h00);
      chk("R11 inv differs", {7'd0, b_cf_i}, 8'h01);
      chk("R11 inv ext wins", b_bus_i, 8'hF0);

      neg(); quiet();
      done = 1'b1;
      summary();
   end
endmodule